// File: doc/BRIEF.md
# Axis Threshold Interrupt Unit

This block watches a stream of three-axis signed samples and raises an interrupt when any axis moves beyond a programmable magnitude limit. Each axis has its own 15-bit threshold. A sample whose magnitude is strictly above its axis limit produces an "above" event when the sample is positive and a "below" event when it is negative. Six such events, two per axis, are gated by a per-event enable mask. They are gathered into a status byte together with an interrupt-active summary bit, and that bit drives the interrupt pin.

Software uses a small synchronous byte-wide register port. It programs the thresholds and the control byte (event enables plus a latch-mode bit), and it reads the status byte. Reading the status returns its current contents and then clears it, which releases the interrupt. In live mode the status is recomputed from every valid sample. In latched mode the first enabled event freezes the status, and the interrupt stays asserted across later samples until software reads it.

Top module: `axis_thresh_irq`

## Requirements
- R1: After reset, every register (control 0x30, status 0x31, threshold bytes 0x32..0x37) reads 0x00 and `irq_out` is low.
- R2: Axis thresholds are 15 bits wide. The upper byte of X, Y and Z sits at 0x32, 0x34 and 0x36 and holds bits 14..8 in its bits 6..0, with bit 7 always reading 0. The lower byte at 0x33, 0x35 and 0x37 holds bits 7..0.
- R3: An axis produces an above event when the sample is positive and its magnitude is strictly greater than the threshold. It produces a below event when the sample is negative and its magnitude is strictly greater than the threshold. A magnitude equal to the threshold produces no event, and the most negative sample value counts with magnitude 32768.
- R4: Control register 0x30 holds an enable for each event in bits 5..0, in the same bit positions as the status flags. Bit 6 selects latched mode. A disabled event never sets its status flag.
- R5: The status byte at 0x31 is laid out as bit 6 interrupt-active, bit 5 Z-above, bit 4 Z-below, bit 3 Y-above, bit 2 Y-below, bit 1 X-above and bit 0 X-below. Interrupt-active is 1 exactly when any of bits 5..0 is 1, and `irq_out` equals it.
- R6: In live mode each valid sample replaces the status with its enabled events one cycle later, so `irq_out` falls without a read once a sample has no enabled event.
- R7: In latched mode, once interrupt-active is set, later samples leave the status unchanged and `irq_out` stays high until the status is read.
- R8: A status read returns the status as it was before the read, clears the whole status in the following cycle and drops `irq_out`.
- R9: When a status read and a valid sample fall in the same cycle, the read returns the old status, and the enabled events of that sample form the new status, in either mode.
- R10: The status register is read-only: a write to 0x31 changes nothing.
- R11: Sample inputs are ignored while `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | 16 | Signed X sample |
| smp_y | input | 16 | Signed Y sample |
| smp_z | input | 16 | Signed Z sample |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid the cycle after a read |
| irq_out | output | 1 | Interrupt, high while interrupt-active is set |

## Verification
The bench aims at the edges of the comparison. It drives samples equal to the threshold, one step above it, and the most negative value against the largest threshold. A design using a non-strict compare, or a sign-extended magnitude that overflows, would flag the wrong events there. In latched mode it sends a second qualifying sample on another axis and checks that the status has not changed. It also issues a read in the same cycle as a new event: a design that let the clear win would lose that event, and one that refreshed before the read would return the wrong byte. Writes to the status address, samples presented with the strobe low, and a threshold upper byte written with bit 7 set round out the cases. Each of these would show up as a wrong read byte or a stray interrupt.

// File: rtl/ati_pkg.sv
package ati_pkg;
  localparam int AXES      = 3;
  localparam int N_EV      = 2 * AXES;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 8'h30;
  localparam logic [ADDR_W-1:0] ADDR_STATUS   = 8'h31;
  localparam logic [ADDR_W-1:0] ADDR_THR_BASE = 8'h32;

  localparam int CTRL_LATCH_BIT = N_EV;

  typedef struct packed {
    logic             ia;
    logic [N_EV-1:0]  ev;
  } status_t;
endpackage

// File: rtl/ati_axis_cmp.sv
module ati_axis_cmp #(
  parameter int DATA_W = 16,
  parameter int THR_W  = 15
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [THR_W-1:0]  thr,
  output logic                     hit_above,
  output logic                     hit_below
);
  localparam int MAG_W = DATA_W + 1;

  logic              neg;
  logic [MAG_W-1:0]  ext;
  logic [MAG_W-1:0]  mag;
  logic [MAG_W-1:0]  thr_ext;
  logic              exceed;

  always_comb begin
    neg     = sample[DATA_W-1];
    ext     = {sample[DATA_W-1], sample};
    mag     = neg ? (~ext + 1'b1) : ext;
    thr_ext = {{(MAG_W-THR_W){1'b0}}, thr};
    exceed  = mag > thr_ext;
    hit_above = exceed && !neg;
    hit_below = exceed && neg;
  end
endmodule

// File: rtl/ati_regfile.sv
module ati_regfile
  import ati_pkg::*;
#(
  parameter int THR_W = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [REG_W-1:0]       wdata,
  output logic [AXES*THR_W-1:0]  thr_flat,
  output logic [N_EV-1:0]        ev_en,
  output logic                   latch_mode,
  output logic                   cfg_hit,
  output logic [REG_W-1:0]       cfg_rbyte
);
  localparam int HI_W = THR_W - REG_W;

  logic [N_EV:0]      ctrl_q;
  logic [N_EV:0]      ctrl_d;
  logic               ctrl_we;

  logic [AXES-1:0]    hi_sel;
  logic [AXES-1:0]    lo_sel;
  logic [REG_W-1:0]   hi_byte [AXES];
  logic [REG_W-1:0]   lo_byte [AXES];

  assign ctrl_we = wr && (addr == ADDR_CTRL);
  assign ctrl_d  = wdata[N_EV:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  assign ev_en      = ctrl_q[N_EV-1:0];
  assign latch_mode = ctrl_q[CTRL_LATCH_BIT];

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic [HI_W-1:0]  hi_q;
    logic [REG_W-1:0] lo_q;
    logic             hi_we;
    logic             lo_we;

    assign hi_sel[a] = (addr == ADDR_W'(ADDR_THR_BASE + 2*a));
    assign lo_sel[a] = (addr == ADDR_W'(ADDR_THR_BASE + 2*a + 1));
    assign hi_we     = wr && hi_sel[a];
    assign lo_we     = wr && lo_sel[a];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_q <= '0;
      else if (hi_we) hi_q <= wdata[HI_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_q <= '0;
      else if (lo_we) lo_q <= wdata;
    end

    assign thr_flat[a*THR_W +: THR_W] = {hi_q, lo_q};
    assign hi_byte[a] = {{(REG_W-HI_W){1'b0}}, hi_q};
    assign lo_byte[a] = lo_q;
  end

  always_comb begin
    cfg_hit   = 1'b0;
    cfg_rbyte = '0;
    if (addr == ADDR_CTRL) begin
      cfg_hit   = 1'b1;
      cfg_rbyte = {{(REG_W-N_EV-1){1'b0}}, ctrl_q};
    end
    for (int a = 0; a < AXES; a++) begin
      if (hi_sel[a]) begin
        cfg_hit   = 1'b1;
        cfg_rbyte = hi_byte[a];
      end
      if (lo_sel[a]) begin
        cfg_hit   = 1'b1;
        cfg_rbyte = lo_byte[a];
      end
    end
  end
endmodule

// File: rtl/ati_status.sv
module ati_status
  import ati_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [N_EV-1:0]  ev_raw,
  input  logic [N_EV-1:0]  ev_en,
  input  logic             latch_mode,
  input  logic             clr,
  output status_t          st
);
  status_t            st_q;
  status_t            st_d;
  status_t            base;
  logic               hold;
  logic               upd;
  logic [N_EV-1:0]    ev_gated;

  always_comb begin
    ev_gated = ev_raw & ev_en;
    base     = clr ? '0 : st_q;
    hold     = latch_mode && base.ia;
    upd      = smp_valid && !hold;
    st_d     = base;
    if (upd) begin
      st_d.ev = ev_gated;
      st_d.ia = |ev_gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/axis_thresh_irq.sv
module axis_thresh_irq
  import ati_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int THR_W  = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_valid,
  input  logic signed [DATA_W-1:0] smp_x,
  input  logic signed [DATA_W-1:0] smp_y,
  input  logic signed [DATA_W-1:0] smp_z,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  output logic                     irq_out
);
  logic [AXES*THR_W-1:0]     thr_flat;
  logic [N_EV-1:0]           ev_en;
  logic                      latch_mode;
  logic                      cfg_hit;
  logic [REG_W-1:0]          cfg_rbyte;
  logic signed [DATA_W-1:0]  smp_arr [AXES];
  logic [N_EV-1:0]           ev_raw;
  logic                      st_clr;
  status_t                   st;
  logic [N_EV-1:0]           st_flags;
  logic                      st_ia;
  logic [REG_W-1:0]          rdata_d;
  logic [REG_W-1:0]          rdata_q;

  assign smp_arr[0] = smp_x;
  assign smp_arr[1] = smp_y;
  assign smp_arr[2] = smp_z;

  ati_regfile #(.THR_W(THR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .thr_flat   (thr_flat),
    .ev_en      (ev_en),
    .latch_mode (latch_mode),
    .cfg_hit    (cfg_hit),
    .cfg_rbyte  (cfg_rbyte)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_cmp
    ati_axis_cmp #(.DATA_W(DATA_W), .THR_W(THR_W)) u_cmp (
      .sample    (smp_arr[a]),
      .thr       (thr_flat[a*THR_W +: THR_W]),
      .hit_above (ev_raw[2*a+1]),
      .hit_below (ev_raw[2*a])
    );
  end

  assign st_clr = reg_rd && (reg_addr == ADDR_STATUS);

  ati_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .ev_raw     (ev_raw),
    .ev_en      (ev_en),
    .latch_mode (latch_mode),
    .clr        (st_clr),
    .st         (st)
  );

  assign st_flags = st.ev;
  assign st_ia    = st.ia;

  always_comb begin
    rdata_d = '0;
    if (reg_addr == ADDR_STATUS) rdata_d = {{(REG_W-N_EV-1){1'b0}}, st};
    else if (cfg_hit)            rdata_d = cfg_rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rdata_d;
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = st_ia;
endmodule

// File: rtl/ati_checker.sv
module ati_checker
  import ati_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              irq_out,
  input logic [N_EV-1:0]   st_flags,
  input logic              latch_mode
);
  logic stat_rd;
  logic hi_rd;
  assign stat_rd = reg_rd && (reg_addr == ADDR_STATUS);
  assign hi_rd   = reg_rd && (reg_addr == 8'h32 || reg_addr == 8'h34 || reg_addr == 8'h36);

  assert_clear_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !smp_valid |=> !irq_out && (st_flags == '0));

  assert_latched_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch_mode && irq_out && !stat_rd |=> irq_out && $stable(st_flags));

  assert_hi_byte_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> !reg_rdata[REG_W-1]);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid && !stat_rd |=> $stable(st_flags) && $stable(irq_out));

  assert_sign_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_flags[0] && st_flags[1]) && !(st_flags[2] && st_flags[3]) && !(st_flags[4] && st_flags[5]));

  assert_irq_any_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (st_flags != '0));
endmodule

bind axis_thresh_irq ati_checker chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_valid  (smp_valid),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out),
  .st_flags   (st_flags),
  .latch_mode (latch_mode)
);

// File: tb/axis_thresh_irq_tb_top.sv
module axis_thresh_irq_tb_top;
  logic               clk;
  logic               rst_n;
  logic               smp_valid;
  logic signed [15:0] smp_x, smp_y, smp_z;
  logic [7:0]         reg_addr;
  logic               reg_wr, reg_rd;
  logic [7:0]         reg_wdata;
  logic [7:0]         reg_rdata;
  logic               irq_out;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  axis_thresh_irq dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: pops expected read bytes once read data has been registered
  always begin
    @(posedge clk);
    if (reg_rd) begin
      @(negedge clk);
      if (exp_q.size() != 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s: rdata actual=%02h expected=%02h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic smp(input logic signed [15:0] x, input logic signed [15:0] y,
                     input logic signed [15:0] z);
    smp_x = x; smp_y = y; smp_z = z; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic rd_smp(input logic [7:0] e, input logic signed [15:0] x,
                        input logic signed [15:0] y, input logic signed [15:0] z,
                        input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = 8'h31; reg_rd = 1'b1;
    smp_x = x; smp_y = y; smp_z = z; smp_valid = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      failures++;
      $display("FAIL %s: irq_out actual=%0b expected=%0b", t, irq_out, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_x = '0; smp_y = '0; smp_z = '0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 reset irq");
    for (int a = 8'h30; a <= 8'h37; a++) rd(8'(a), 8'h00, "R1 reset reg");

    // R2 thresholds: X=0x1234 (bit7 of upper write dropped), Y=0x0064, Z=0x7FFF
    wr(8'h32, 8'h92); wr(8'h33, 8'h34);
    wr(8'h34, 8'h00); wr(8'h35, 8'h64);
    wr(8'h36, 8'hFF); wr(8'h37, 8'hFF);
    rd(8'h32, 8'h12, "R2 X upper");
    rd(8'h33, 8'h34, "R2 X lower");
    rd(8'h35, 8'h64, "R2 Y lower");
    rd(8'h36, 8'h7F, "R2 Z upper bit7 zero");
    rd(8'h37, 8'hFF, "R2 Z lower");

    // live mode, all events enabled
    wr(8'h30, 8'h3F);
    rd(8'h30, 8'h3F, "R4 control readback");
    smp(16'sh1235, -16'sd101, 16'sd5);
    chk_irq(1'b1, "R6 live event");
    wr(8'h31, 8'h00);
    rd(8'h31, 8'h46, "R10 status write ignored / R3 XH YL / R5");
    chk_irq(1'b0, "R8 read drops irq");
    rd(8'h31, 8'h00, "R8 status cleared");

    smp(16'sh1235, 16'sd0, 16'sd0);
    chk_irq(1'b1, "R6 event again");
    smp_x = 16'sh0000; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_irq(1'b1, "R11 invalid sample ignored");
    smp(16'sh1234, -16'sd100, 16'sh7FFF);
    chk_irq(1'b0, "R3 equal magnitude / R6 live drop");
    rd(8'h31, 8'h00, "R3 equal threshold no event");

    smp(-16'sd4661, 16'sd101, -16'sd32768);
    rd(8'h31, 8'h59, "R3 XL YH ZL incl most negative");

    // R4 enable mask: only X-below enabled
    wr(8'h30, 8'h01);
    smp(16'sh2000, 16'sd0, 16'sd0);
    chk_irq(1'b0, "R4 disabled event");
    smp(-16'sh2000, 16'sd500, 16'sd0);
    rd(8'h31, 8'h41, "R4 only enabled flag");

    // latched mode
    wr(8'h30, 8'h7F);
    smp(16'sh1235, 16'sd0, 16'sd0);
    smp(16'sd0, -16'sd101, 16'sd0);
    smp(16'sd0, 16'sd0, 16'sd0);
    chk_irq(1'b1, "R7 latched irq held");
    rd(8'h31, 8'h42, "R7 latched status frozen");
    chk_irq(1'b0, "R8 latched read releases");

    smp(16'sh1235, 16'sd0, 16'sd0);
    rd_smp(8'h42, 16'sd0, -16'sd101, 16'sd0, "R9 read with event returns old");
    chk_irq(1'b1, "R9 new event captured");
    rd(8'h31, 8'h44, "R9 new status");

    while (exp_q.size() != 0) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule